// File: doc/BRIEF.md
# Shift, Rotate and Bit-Field Unit

This block is the word-manipulation unit of a 16-bit fixed-point signal processor datapath. In a single pass it moves a data word left or right by a signed count, with either zero fill or sign fill. It can also rotate the word, pull a bit field out of it, or insert a bit field into it. Finally, it can set, clear, flip or probe one selected bit. The operation code picks the function. The count input doubles as the field start or bit index, and a separate length input sizes the field.

The result and the probe flag are registered. A new operation can be issued every clock, and its outcome appears on the outputs after the next rising edge. Block floating-point exponent detection and extended-precision modes are not part of this unit.

Top module: `bsh_unit`

## Requirements
- R1: While `rst_ni` is low, `result_o` and `flag_o` are 0. The asynchronous reset clears them without waiting for a clock edge.
- R2: Inputs present at a rising edge appear on `result_o` and `flag_o` right after that edge. The outputs do not change between edges.
- R3: Op code 0 is a logical shift. `amt_i` is a 5-bit two's complement count: a positive count shifts left, a negative count shifts right by its magnitude, and vacated bits fill with 0.
- R4: Op code 1 is an arithmetic shift. A left shift behaves as in R3. A right shift fills the vacated bits with copies of bit 15 of `data_i`.
- R5: A count of -16 (`amt_i` = 5'b10000) gives 0 for the logical shift. For the arithmetic shift it gives sixteen copies of bit 15.
- R6: Op code 2 rotates the word: a positive count rotates left, and a negative count rotates right by its magnitude. A count of -16 returns the word unchanged.
- R7: Op code 3 extracts a field. The field starts at bit `amt_i[3:0]` and is `len_i` bits long. It is returned right-justified and zero-extended. Positions above bit 15 read as 0, a length of 0 gives 0, and lengths of 16 or more cover the whole word.
- R8: Op code 4 deposits a field. The low `len_i` bits of `ins_i` replace the bits of `data_i` starting at bit `amt_i[3:0]`. Field bits that would land above bit 15 are dropped, and every bit outside the field keeps its value from `data_i`.
- R9: Op codes 5, 6 and 7 set, clear and toggle, in that order, bit `amt_i[3:0]` of `data_i`. All other bits pass through unchanged.
- R10: Op code 8 tests a bit. `result_o` equals `data_i`, and `flag_o` equals bit `amt_i[3:0]` of `data_i`.
- R11: `flag_o` is 0 for every op code other than 8. Op codes 9 to 15 return `data_i` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| data_i | input | 16 | Operand word |
| ins_i | input | 16 | Field source word for deposit |
| amt_i | input | 5 | Signed shift count, or bit / field start in bits [3:0] |
| len_i | input | 5 | Field length in bits |
| result_o | output | 16 | Registered result word |
| flag_o | output | 1 | Registered bit-test flag |

## Verification
Bit test is the one function that drives both outputs in the same cycle: the flag carries the probed bit while the word must pass through untouched. Back-to-back issues make the flag rise and fall between neighbouring operations. The bench issues a test right after a set, clear or toggle on the same bit index, so the flag of one cycle and the modified word of the previous cycle are judged at adjacent edges. The scoreboard compares both outputs of every item, so a flag that leaks into a non-test cycle, or a test that alters the word, is reported against R10 or R11.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

    typedef enum logic [3:0] {
        OP_LSH = 4'd0,
        OP_ASH = 4'd1,
        OP_ROT = 4'd2,
        OP_EXT = 4'd3,
        OP_DEP = 4'd4,
        OP_SET = 4'd5,
        OP_CLR = 4'd6,
        OP_TGL = 4'd7,
        OP_TST = 4'd8
    } op_e;

endpackage

// File: rtl/bsh_shift_core.sv
// Log-depth shifter: left, right (zero or sign fill) and rotate networks.
module bsh_shift_core #(
    parameter int W  = 16,
    parameter int AW = $clog2(W) + 1
) (
    input  logic [W-1:0]  data_i,
    input  logic [AW-1:0] amt_i,
    output logic [W-1:0]  lsh_o,
    output logic [W-1:0]  ash_o,
    output logic [W-1:0]  rot_o
);
    localparam int SW = AW - 1;   // stages for counts below W

    logic          neg;
    logic [AW-1:0] mag;
    logic          sgn;

    assign neg = amt_i[AW-1];
    assign mag = neg ? (~amt_i + AW'(1)) : amt_i;
    assign sgn = data_i[W-1];

    logic [W-1:0] lft [0:SW];
    logic [W-1:0] rol [0:SW];
    logic [W-1:0] rzf [0:AW];
    logic [W-1:0] rsf [0:AW];

    assign lft[0] = data_i;
    assign rol[0] = data_i;
    assign rzf[0] = data_i;
    assign rsf[0] = data_i;

    for (genvar k = 0; k < SW; k++) begin : g_left
        localparam int S = 1 << k;
        assign lft[k+1] = mag[k]   ? {lft[k][W-S-1:0], {S{1'b0}}}         : lft[k];
        // two's complement count mod W is the left-rotate distance
        assign rol[k+1] = amt_i[k] ? {rol[k][W-S-1:0], rol[k][W-1:W-S]}   : rol[k];
    end

    for (genvar k = 0; k < AW; k++) begin : g_right
        localparam int S = 1 << k;
        if (S >= W) begin : g_full
            assign rzf[k+1] = mag[k] ? '0       : rzf[k];
            assign rsf[k+1] = mag[k] ? {W{sgn}} : rsf[k];
        end else begin : g_part
            assign rzf[k+1] = mag[k] ? {{S{1'b0}}, rzf[k][W-1:S]} : rzf[k];
            assign rsf[k+1] = mag[k] ? {{S{sgn}},  rsf[k][W-1:S]} : rsf[k];
        end
    end

    assign lsh_o = neg ? rzf[AW] : lft[SW];
    assign ash_o = neg ? rsf[AW] : lft[SW];
    assign rot_o = rol[SW];

endmodule

// File: rtl/bsh_field_unit.sv
// Bit-field extract and deposit.
module bsh_field_unit #(
    parameter int W  = 16,
    parameter int PW = $clog2(W),
    parameter int LW = PW + 1
) (
    input  logic [W-1:0]  data_i,
    input  logic [W-1:0]  ins_i,
    input  logic [PW-1:0] pos_i,
    input  logic [LW-1:0] len_i,
    output logic [W-1:0]  ext_o,
    output logic [W-1:0]  dep_o
);
    logic [W-1:0] len_mask;
    logic [W-1:0] fld_mask;

    for (genvar i = 0; i < W; i++) begin : g_mask
        assign len_mask[i] = (LW'(i) < len_i);
    end

    assign fld_mask = len_mask << pos_i;
    assign ext_o    = (data_i >> pos_i) & len_mask;
    assign dep_o    = (data_i & ~fld_mask) | ((ins_i << pos_i) & fld_mask);

endmodule

// File: rtl/bsh_bit_unit.sv
// Single-bit set, clear, toggle and probe.
module bsh_bit_unit #(
    parameter int W  = 16,
    parameter int PW = $clog2(W)
) (
    input  logic [W-1:0]  data_i,
    input  logic [PW-1:0] pos_i,
    output logic [W-1:0]  set_o,
    output logic [W-1:0]  clr_o,
    output logic [W-1:0]  tgl_o,
    output logic          tst_o
);
    logic [W-1:0] sel;

    for (genvar i = 0; i < W; i++) begin : g_sel
        assign sel[i] = (pos_i == PW'(i));
    end

    assign set_o = data_i | sel;
    assign clr_o = data_i & ~sel;
    assign tgl_o = data_i ^ sel;
    assign tst_o = |(data_i & sel);

endmodule

// File: rtl/bsh_unit.sv
module bsh_unit
    import bsh_pkg::*;
#(
    parameter int W  = 16,
    parameter int PW = $clog2(W),
    parameter int AW = PW + 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [3:0]    op_i,
    input  logic [W-1:0]  data_i,
    input  logic [W-1:0]  ins_i,
    input  logic [AW-1:0] amt_i,
    input  logic [AW-1:0] len_i,
    output logic [W-1:0]  result_o,
    output logic          flag_o
);
    typedef struct packed {
        logic [W-1:0] word;
        logic         flag;
    } bsh_state_t;

    bsh_state_t st_d, st_q;
    op_e        op;

    logic [W-1:0] lsh_w, ash_w, rot_w;
    logic [W-1:0] ext_w, dep_w;
    logic [W-1:0] set_w, clr_w, tgl_w;
    logic         tst_w;

    assign op = op_e'(op_i);

    bsh_shift_core #(.W(W), .AW(AW)) u_shift (
        .data_i (data_i),
        .amt_i  (amt_i),
        .lsh_o  (lsh_w),
        .ash_o  (ash_w),
        .rot_o  (rot_w)
    );

    bsh_field_unit #(.W(W), .PW(PW), .LW(AW)) u_field (
        .data_i (data_i),
        .ins_i  (ins_i),
        .pos_i  (amt_i[PW-1:0]),
        .len_i  (len_i),
        .ext_o  (ext_w),
        .dep_o  (dep_w)
    );

    bsh_bit_unit #(.W(W), .PW(PW)) u_bit (
        .data_i (data_i),
        .pos_i  (amt_i[PW-1:0]),
        .set_o  (set_w),
        .clr_o  (clr_w),
        .tgl_o  (tgl_w),
        .tst_o  (tst_w)
    );

    always_comb begin
        st_d.word = data_i;
        st_d.flag = 1'b0;
        case (op)
            OP_LSH:  st_d.word = lsh_w;
            OP_ASH:  st_d.word = ash_w;
            OP_ROT:  st_d.word = rot_w;
            OP_EXT:  st_d.word = ext_w;
            OP_DEP:  st_d.word = dep_w;
            OP_SET:  st_d.word = set_w;
            OP_CLR:  st_d.word = clr_w;
            OP_TGL:  st_d.word = tgl_w;
            OP_TST:  st_d.flag = tst_w;
            default: st_d.word = data_i;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.word;
    assign flag_o   = st_q.flag;

endmodule

// File: rtl/bsh_unit_chk.sv
module bsh_unit_chk
    import bsh_pkg::*;
#(
    parameter int W  = 16,
    parameter int PW = $clog2(W),
    parameter int AW = PW + 1
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic [3:0]    op_i,
    input logic [W-1:0]  data_i,
    input logic [AW-1:0] amt_i,
    input logic [AW-1:0] len_i,
    input logic [W-1:0]  result_o,
    input logic          flag_o
);
    logic         armed_q;
    logic         tbit;
    logic [W-1:0] onehot;
    logic [W-1:0] fmask;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) armed_q <= 1'b0;
        else         armed_q <= 1'b1;
    end

    assign tbit   = data_i[amt_i[PW-1:0]];
    assign onehot = W'(1) << amt_i[PW-1:0];

    always_comb begin
        for (int i = 0; i < W; i++) begin
            fmask[i] = (i >= int'(amt_i[PW-1:0])) &&
                       ((i - int'(amt_i[PW-1:0])) < int'(len_i));
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk_i)
        !rst_ni |-> (result_o == '0 && !flag_o));

    assert_lsh_full_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && $past(op_i) == OP_LSH && $past(amt_i) == AW'(W)) |-> (result_o == '0));

    assert_ash_sign_fill_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && $past(op_i) == OP_ASH && $past(amt_i) == AW'(W))
        |-> (result_o == {W{$past(data_i[W-1])}}));

    assert_rot_full_turn_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && $past(op_i) == OP_ROT && $past(amt_i) == AW'(W))
        |-> (result_o == $past(data_i)));

    assert_deposit_scope_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && $past(op_i) == OP_DEP)
        |-> (((result_o ^ $past(data_i)) & ~$past(fmask)) == '0));

    assert_clear_scope_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && $past(op_i) == OP_CLR)
        |-> ((((result_o ^ $past(data_i)) & ~$past(onehot)) == '0) &&
             ((result_o & $past(onehot)) == '0)));

    assert_test_keeps_word_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && $past(op_i) == OP_TST)
        |-> (result_o == $past(data_i) && flag_o == $past(tbit)));

    assert_flag_only_test_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && $past(op_i) != OP_TST) |-> !flag_o);

endmodule

bind bsh_unit bsh_unit_chk #(.W(W), .PW(PW), .AW(AW)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op_i),
    .data_i   (data_i),
    .amt_i    (amt_i),
    .len_i    (len_i),
    .result_o (result_o),
    .flag_o   (flag_o)
);

// File: tb/tb_bsh_unit.sv
module tb_bsh_unit;
    localparam int W = 16;

    logic          clk_i = 1'b0;
    logic          rst_ni;
    logic [3:0]    op_i;
    logic [W-1:0]  data_i;
    logic [W-1:0]  ins_i;
    logic [4:0]    amt_i;
    logic [4:0]    len_i;
    logic [W-1:0]  result_o;
    logic          flag_o;

    always #5 clk_i = ~clk_i;

    bsh_unit dut (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .op_i     (op_i),
        .data_i   (data_i),
        .ins_i    (ins_i),
        .amt_i    (amt_i),
        .len_i    (len_i),
        .result_o (result_o),
        .flag_o   (flag_o)
    );

    typedef struct {
        logic [W-1:0] word;
        logic         flag;
        string        req;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    function automatic exp_t model(input logic [3:0] op, input logic [W-1:0] d,
                                   input logic [W-1:0] ins, input logic [4:0] amt,
                                   input logic [4:0] len, input string req);
        exp_t e;
        int a;
        int pos;
        int ln;
        int k;
        logic signed [31:0] s;
        a   = $signed(amt);
        pos = int'(amt[3:0]);
        ln  = int'(len);
        e.word = d;
        e.flag = 1'b0;
        e.req  = req;
        case (op)
            4'd0: e.word = (a >= 0) ? (d << a) : (d >> (-a));
            4'd1: begin
                if (a >= 0) e.word = d << a;
                else begin
                    s = {{16{d[15]}}, d};
                    s = s >>> (-a);
                    e.word = s[15:0];
                end
            end
            4'd2: begin
                k = ((a % W) + W) % W;
                for (int i = 0; i < W; i++) e.word[(i + k) % W] = d[i];
            end
            4'd3: begin
                e.word = '0;
                for (int i = 0; i < ln && i < W; i++)
                    if (pos + i < W) e.word[i] = d[pos + i];
            end
            4'd4: begin
                for (int i = 0; i < ln && i < W; i++)
                    if (pos + i < W) e.word[pos + i] = ins[i];
            end
            4'd5: e.word[pos] = 1'b1;
            4'd6: e.word[pos] = 1'b0;
            4'd7: e.word[pos] = ~d[pos];
            4'd8: e.flag = d[pos];
            default: ;
        endcase
        return e;
    endfunction

    task automatic issue(input logic [3:0] op, input logic [W-1:0] d,
                         input logic [W-1:0] ins, input logic [4:0] amt,
                         input logic [4:0] len, input string req);
        @(negedge clk_i);
        op_i   = op;
        data_i = d;
        ins_i  = ins;
        amt_i  = amt;
        len_i  = len;
        sb.push_back(model(op, d, ins, amt, len, req));
    endtask

    task automatic check(input bit ok, input string req, input logic [W-1:0] act_w,
                         input logic act_f, input logic [W-1:0] exp_w, input logic exp_f);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual word=%h flag=%0b expected word=%h flag=%0b",
                     req, act_w, act_f, exp_w, exp_f);
        end
    endtask

    task automatic drain();
        while (sb.size() > 0) @(negedge clk_i);
        @(negedge clk_i);
    endtask

    // monitor: one-cycle latency scoreboard (R2)
    initial begin
        exp_t e;
        forever begin
            @(posedge clk_i);
            #1;
            if (sb.size() > 0 && rst_ni) begin
                e = sb.pop_front();
                check(result_o === e.word && flag_o === e.flag, e.req,
                      result_o, flag_o, e.word, e.flag);
            end
        end
    end

    initial begin
        #1_500_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] held;
        rst_ni = 1'b0;
        op_i = 4'd0; data_i = '0; ins_i = '0; amt_i = '0; len_i = '0;
        #2;
        check(result_o == '0 && !flag_o, "R1", result_o, flag_o, '0, 1'b0);
        repeat (3) @(negedge clk_i);
        check(result_o == '0 && !flag_o, "R1", result_o, flag_o, '0, 1'b0);
        rst_ni = 1'b1;

        // R3 logical shifts
        issue(4'd0, 16'h8001, '0, 5'd1,  '0, "R3");
        issue(4'd0, 16'h8001, '0, 5'h1F, '0, "R3");
        issue(4'd0, 16'h1234, '0, 5'd15, '0, "R3");
        issue(4'd0, 16'hF00F, '0, 5'h11, '0, "R3");
        // R4 arithmetic shifts
        issue(4'd1, 16'h8000, '0, 5'h1F, '0, "R4");
        issue(4'd1, 16'h4000, '0, 5'h1D, '0, "R4");
        issue(4'd1, 16'h9003, '0, 5'd3,  '0, "R4");
        issue(4'd1, 16'hA5A5, '0, 5'h11, '0, "R4");
        // R5 full-width right shifts
        issue(4'd0, 16'hFFFF, '0, 5'h10, '0, "R5");
        issue(4'd1, 16'h8001, '0, 5'h10, '0, "R5");
        issue(4'd1, 16'h7FFF, '0, 5'h10, '0, "R5");
        // R6 rotates
        issue(4'd2, 16'h8001, '0, 5'd1,  '0, "R6");
        issue(4'd2, 16'h8001, '0, 5'h1F, '0, "R6");
        issue(4'd2, 16'hBEEF, '0, 5'h10, '0, "R6");
        issue(4'd2, 16'h1235, '0, 5'd15, '0, "R6");
        // R7 extract
        issue(4'd3, 16'hABCD, '0, 5'd4,  5'd8,  "R7");
        issue(4'd3, 16'hABCD, '0, 5'd12, 5'd8,  "R7");
        issue(4'd3, 16'hABCD, '0, 5'd3,  5'd0,  "R7");
        issue(4'd3, 16'hABCD, '0, 5'd0,  5'd16, "R7");
        issue(4'd3, 16'hABCD, '0, 5'd5,  5'd31, "R7");
        // R8 deposit
        issue(4'd4, 16'hFFFF, 16'h0000, 5'd4,  5'd4,  "R8");
        issue(4'd4, 16'h0000, 16'hFFFF, 5'd14, 5'd4,  "R8");
        issue(4'd4, 16'h1234, 16'hABCD, 5'd0,  5'd16, "R8");
        issue(4'd4, 16'h5555, 16'h00FF, 5'd7,  5'd0,  "R8");
        // R9 then R10 on the same bit, back to back
        issue(4'd5, 16'h0000, '0, 5'd9,  '0, "R9");
        issue(4'd8, 16'h0200, '0, 5'd9,  '0, "R10");
        issue(4'd6, 16'hFFFF, '0, 5'd0,  '0, "R9");
        issue(4'd8, 16'hFFFE, '0, 5'd0,  '0, "R10");
        issue(4'd7, 16'h00F0, '0, 5'd15, '0, "R9");
        issue(4'd8, 16'h80F0, '0, 5'd15, '0, "R10");
        issue(4'd0, 16'h80F0, '0, 5'd0,  '0, "R11");
        // R11 unused codes
        for (int c = 9; c < 16; c++) issue(4'(c), 16'hC3A5, 16'hFFFF, 5'd3, 5'd4, "R11");
        drain();

        // R2: outputs hold between edges
        held = result_o;
        @(negedge clk_i);
        op_i = 4'd7; data_i = ~held; amt_i = 5'd2;
        #2;
        check(result_o == held, "R2", result_o, flag_o, held, flag_o);
        @(posedge clk_i); #1;
        check(result_o == model(4'd7, ~held, '0, 5'd2, '0, "R2").word, "R2",
              result_o, flag_o, model(4'd7, ~held, '0, 5'd2, '0, "R2").word, 1'b0);

        // random traffic
        for (int n = 0; n < 600; n++) begin
            logic [3:0] op;
            string      r;
            op = 4'($urandom_range(0, 11));
            case (op)
                4'd0: r = "R3";  4'd1: r = "R4";  4'd2: r = "R6";
                4'd3: r = "R7";  4'd4: r = "R8";  4'd5, 4'd6, 4'd7: r = "R9";
                4'd8: r = "R10"; default: r = "R11";
            endcase
            issue(op, 16'($urandom), 16'($urandom), 5'($urandom), 5'($urandom), r);
        end
        drain();

        // R1: asynchronous reset mid-run
        issue(4'd5, 16'h0000, '0, 5'd3, '0, "R9");
        drain();
        @(negedge clk_i);
        rst_ni = 1'b0;
        #1;
        check(result_o == '0 && !flag_o, "R1", result_o, flag_o, '0, 1'b0);
        @(negedge clk_i);
        rst_ni = 1'b1;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule